// File: doc/BRIEF.md
# SD/MMC Host Event Status and Interrupt Aggregator

This block gathers the event pulses of an SD/MMC host controller into a 16-bit status word. The sources are command completion, response timeout, data completion, card error, card busy, card insertion and two FIFO threshold levels. A 15-bit enable mask selects which status bits may raise the single level-sensitive interrupt line. Most status bits are sticky: an event pulse sets them, and software clears them by writing ones to the status word. The two FIFO threshold bits are not sticky. They mirror the threshold logic and drop on their own when the level falls.

A small register port reaches both words. `bus_sel` = 0 selects the status word and `bus_sel` = 1 selects the mask. Reads are combinational from the selected word. A write with `bus_sel` = 0 clears status bits (write-one-to-clear), and a write with `bus_sel` = 1 loads the mask.

Top module: `sdh_irq_agg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word and the mask become zero, so `irq` is low.
- R2: `irq` is high exactly when the stored status word AND the stored mask is non-zero. It reflects the registers in the same cycle they change.
- R3: A write with `bus_sel`=0 clears every sticky status bit whose write-data bit is one. Bits written with zero keep their value.
- R4: A write with `bus_sel`=1 stores `bus_wdata[14:0]` as the mask. Reading the mask (`bus_sel`=1) returns bit 15 as zero.
- R5: A `cmd_end` pulse without `cmd_timeout` sets bit 0 (command done). If `cmd_index` equals 12 (stop), bit 2 is set at the same clock edge.
- R6: A `cmd_end` pulse with `cmd_timeout` high sets bit 7 (response timeout) and sets neither bit 0 nor bit 2.
- R7: A pulse on `xfer_done`, `card_err` or `card_busy` sets bit 3, bit 14 or bit 12 respectively. The bit then stays set until it is cleared.
- R8: Bit 1 (card inserted) is set only when `card_present` goes from low to high between two clock edges. A held high level, a falling edge, or a card present throughout reset does not set it.
- R9: Bit 10 equals `rx_almost_full` and bit 11 equals `tx_almost_empty`, each as sampled at the previous clock edge. Bus writes do not change them.
- R10: When a sticky bit receives a set pulse and a bus clear at the same edge, the bit ends up set.
- R11: Status bits 4, 5, 6, 8, 9, 13 and 15 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_end | input | 1 | One-cycle pulse: command phase finished |
| cmd_timeout | input | 1 | Qualifies `cmd_end`: no valid response arrived |
| cmd_index | input | 6 | Index of the finished command |
| xfer_done | input | 1 | Pulse: data transfer complete |
| card_err | input | 1 | Pulse: card status reported an error |
| card_busy | input | 1 | Pulse: card busy during operating-condition query |
| card_present | input | 1 | Card-detect level |
| rx_almost_full | input | 1 | Receive FIFO above its threshold (level) |
| tx_almost_empty | input | 1 | Transmit FIFO below its threshold (level) |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects status, 1 selects mask |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
Every status bit is a separate flop. A corrupted bit therefore appears in `bus_rdata` one cycle after the edge that corrupted it, and also in `irq` whenever that bit is enabled. The reference model is compared on every clock. A lost set, a clear applied to the wrong bit, or a wrong set/clear priority is reported in the same cycle. A card-detect edge detector that fires on level or on falling edges, or that fires at reset release, shows as a bit 1 that appears without an insertion.

// File: rtl/sdh_evt_pkg.sv
// sdh_evt_pkg: bit positions and derived masks of the host event status word.
// Assumes a 16-bit status word. Software decodes the positions, so they are fixed.
package sdh_evt_pkg;
    localparam int STAT_W   = 16;
    localparam int MASK_W   = STAT_W - 1;
    localparam int B_CMD    = 0;
    localparam int B_INS    = 1;
    localparam int B_STOP   = 2;
    localparam int B_XFER   = 3;
    localparam int B_TMO    = 7;
    localparam int B_RXAF   = 10;
    localparam int B_TXAE   = 11;
    localparam int B_BUSY   = 12;
    localparam int B_ERR    = 14;

    localparam logic [STAT_W-1:0] STICKY_M =
        (STAT_W'(1) << B_CMD)  | (STAT_W'(1) << B_INS)  | (STAT_W'(1) << B_STOP) |
        (STAT_W'(1) << B_XFER) | (STAT_W'(1) << B_TMO)  | (STAT_W'(1) << B_BUSY) |
        (STAT_W'(1) << B_ERR);
    localparam logic [STAT_W-1:0] LEVEL_M =
        (STAT_W'(1) << B_RXAF) | (STAT_W'(1) << B_TXAE);
    localparam logic [STAT_W-1:0] SPARE_M = ~(STICKY_M | LEVEL_M);
endpackage

// File: rtl/sdh_evt_set.sv
// sdh_evt_set: turns event pulses into a set vector for the status word.
// Detects card insertion as a rising edge of card_present.
// Assumes event inputs are synchronous one-cycle pulses.
module sdh_evt_set
    import sdh_evt_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int STOP_IDX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_end,
    input  logic              cmd_timeout,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic              xfer_done,
    input  logic              card_err,
    input  logic              card_busy,
    input  logic              card_present,
    output logic [STAT_W-1:0] set_vec
);
    logic cd_prev;

    // Remember the last card-detect level. Reset loads the live level so that
    // a card present at reset release does not count as an insertion.
    always_ff @(posedge clk) begin
        cd_prev <= card_present;
    end

    // Build one set bit per event source.
    always_comb begin
        set_vec = '0;
        if (cmd_end) begin
            if (cmd_timeout) begin
                set_vec[B_TMO] = 1'b1;
            end else begin
                set_vec[B_CMD]  = 1'b1;
                set_vec[B_STOP] = (cmd_index == IDX_W'(STOP_IDX));
            end
        end
        set_vec[B_XFER] = xfer_done;
        set_vec[B_ERR]  = card_err;
        set_vec[B_BUSY] = card_busy;
        set_vec[B_INS]  = rst_n && card_present && !cd_prev;
    end
endmodule

// File: rtl/sdh_stat_reg.sv
// sdh_stat_reg: the status word. Sticky bits are set by pulses and cleared by
// write-one-to-clear, with set taking priority. Level bits copy the FIFO
// threshold inputs. Spare bits are constant zero.
module sdh_stat_reg
    import sdh_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic              lvl_rx,
    input  logic              lvl_tx,
    output logic [STAT_W-1:0] stat_q
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == B_RXAF || i == B_TXAE) begin : g_lvl
            logic q;
            logic src;
            assign src = (i == B_RXAF) ? lvl_rx : lvl_tx;
            // Copy the threshold level each cycle. Bus clears do not apply.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= src;
            end
            assign stat_q[i] = q;
        end else if (STICKY_M[i]) begin : g_sticky
            logic q;
            // Hold until cleared. A set at the same edge wins over a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= set_vec[i] | (q & ~clr_vec[i]);
            end
            assign stat_q[i] = q;
        end else begin : g_spare
            assign stat_q[i] = 1'b0;
        end
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(set_vec) & STICKY_M) & ~stat_q) == '0));

    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(clr_vec) & ~$past(set_vec) & STICKY_M) & stat_q) == '0));

    a_r9_level_rx: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_q[B_RXAF] == $past(lvl_rx)));
endmodule

// File: rtl/sdh_irq_mask.sv
// sdh_irq_mask: interrupt enable mask and the interrupt line.
// Assumes the status word arrives already registered.
module sdh_irq_mask
    import sdh_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] stat_q,
    output logic [MASK_W-1:0] mask_q,
    output logic              irq
);
    // Load the low bits of a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata[MASK_W-1:0];
    end

    // Request whenever an enabled status bit is set.
    always_comb begin
        irq = |(stat_q[MASK_W-1:0] & mask_q);
    end

    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wdata[MASK_W-1:0])));
endmodule

// File: rtl/sdh_irq_agg.sv
// sdh_irq_agg: top of the host event status and interrupt aggregator.
// bus_sel 0 = status (write-one-to-clear), 1 = mask. Reads are combinational.
module sdh_irq_agg
    import sdh_evt_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int STOP_IDX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_end,
    input  logic              cmd_timeout,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic              xfer_done,
    input  logic              card_err,
    input  logic              card_busy,
    input  logic              card_present,
    input  logic              rx_almost_full,
    input  logic              tx_almost_empty,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat_q;
    logic [MASK_W-1:0] mask_q;

    // Route a status-select write to the clear vector.
    always_comb begin
        clr_vec = (bus_wr && !bus_sel) ? bus_wdata : '0;
    end

    sdh_evt_set #(.IDX_W(IDX_W), .STOP_IDX(STOP_IDX)) u_set (
        .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .cmd_timeout(cmd_timeout),
        .cmd_index(cmd_index), .xfer_done(xfer_done), .card_err(card_err),
        .card_busy(card_busy), .card_present(card_present), .set_vec(set_vec)
    );

    sdh_stat_reg u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .lvl_rx(rx_almost_full), .lvl_tx(tx_almost_empty), .stat_q(stat_q)
    );

    sdh_irq_mask u_mask (
        .clk(clk), .rst_n(rst_n), .mask_wr(bus_wr && bus_sel), .wdata(bus_wdata),
        .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
    );

    // Return the selected register. The mask reads with a zero top bit.
    always_comb begin
        bus_rdata = bus_sel ? {1'b0, mask_q} : stat_q;
    end

    a_r8_insert_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (card_present && !$past(card_present)) |=> stat_q[B_INS]);

    a_r5_stop_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && !cmd_timeout && cmd_index == IDX_W'(STOP_IDX))
            |=> (stat_q[B_CMD] && stat_q[B_STOP]));

    a_r11_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> ((bus_rdata & SPARE_M & {STAT_W{!bus_sel}}) == '0));
endmodule

// File: tb/sdh_irq_agg_test.sv
module sdh_irq_agg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_end = 0, cmd_timeout = 0, xfer_done = 0, card_err = 0, card_busy = 0;
    logic [5:0] cmd_index = 0;
    logic card_present = 0, rx_almost_full = 0, tx_almost_empty = 0;
    logic bus_wr = 0, bus_sel = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic irq;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // Reference model state
    int m_st = 0, m_mk = 0, m_cdp = 0;

    always #10 clk = ~clk;

    sdh_irq_agg uut (
        .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .cmd_timeout(cmd_timeout),
        .cmd_index(cmd_index), .xfer_done(xfer_done), .card_err(card_err),
        .card_busy(card_busy), .card_present(card_present),
        .rx_almost_full(rx_almost_full), .tx_almost_empty(tx_almost_empty),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Model update at each edge, then compare a quarter period later.
    always @(posedge clk) begin
        int set_m, clr_m, exp_rd, exp_irq;
        if (!rst_n) begin
            m_st = 0; m_mk = 0; m_cdp = card_present;
        end else begin
            set_m = 0;
            if (cmd_end) begin
                if (cmd_timeout) set_m |= 'h80;
                else begin
                    set_m |= 1;
                    if (cmd_index == 12) set_m |= 4;
                end
            end
            if (xfer_done) set_m |= 'h8;
            if (card_err)  set_m |= 'h4000;
            if (card_busy) set_m |= 'h1000;
            if (card_present && !m_cdp) set_m |= 'h2;
            clr_m = (bus_wr && !bus_sel) ? bus_wdata : 0;
            m_st = (((m_st & ~clr_m) | set_m) & 'h508F)
                   | (rx_almost_full ? 'h400 : 0) | (tx_almost_empty ? 'h800 : 0);
            if (bus_wr && bus_sel) m_mk = bus_wdata & 'h7FFF;
            m_cdp = card_present;
        end
        #5;
        if (!done) begin
            exp_rd  = bus_sel ? m_mk : m_st;
            exp_irq = ((m_st & m_mk) != 0);
            checks++;
            if (bus_rdata !== exp_rd[15:0]) begin
                errors++;
                $display("FAIL %s rdata sel=%0d act %h exp %h", cur_req, bus_sel, bus_rdata, exp_rd[15:0]);
            end
            checks++;
            if (irq !== exp_irq[0]) begin
                errors++;
                $display("FAIL %s irq act %b exp %b", cur_req, irq, exp_irq[0]);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_end = 0; cmd_timeout = 0; xfer_done = 0; card_err = 0; card_busy = 0;
            bus_wr = 0;
        end
    endtask

    task automatic wr(bit sel, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_sel = sel; bus_wdata = d;
        idle(1);
    endtask

    task automatic cmd(logic [5:0] idx, bit tmo);
        @(negedge clk);
        cmd_end = 1; cmd_index = idx; cmd_timeout = tmo;
        idle(1);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog act hung exp finish");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 and R8: reset with a card present
        cur_req = "R1";
        card_present = 1;
        bus_sel = 0;
        idle(3);
        @(negedge clk); rst_n = 1;
        cur_req = "R8";
        idle(3);
        // R4: mask keeps 15 bits
        cur_req = "R4";
        wr(1, 16'hFFFF);
        bus_sel = 1; idle(2);
        wr(1, 16'h0000);
        bus_sel = 0;
        // R5: plain command, then stop command
        cur_req = "R5";
        cmd(6'd5, 0); idle(1);
        wr(0, 16'h0001);
        cmd(6'd12, 0); idle(1);
        // R3: clear only one bit of two
        cur_req = "R3";
        wr(0, 16'h0004); idle(1);
        wr(0, 16'hFFFF); idle(1);
        // R6: timeout on a stop command
        cur_req = "R6";
        cmd(6'd12, 1); idle(1);
        // R7: data done, error, busy
        cur_req = "R7";
        @(negedge clk); xfer_done = 1; idle(1);
        @(negedge clk); card_err = 1; idle(1);
        @(negedge clk); card_busy = 1; idle(2);
        // R2: interrupt gating by mask
        cur_req = "R2";
        wr(1, 16'h0001); bus_sel = 0; idle(1);
        wr(1, 16'h4000); bus_sel = 0; idle(1);
        wr(0, 16'h4000); idle(1);
        wr(1, 16'h0008); bus_sel = 0; idle(1);
        // R8: fall, hold low, rise, hold high
        cur_req = "R8";
        wr(0, 16'hFFFF);
        @(negedge clk); card_present = 0; idle(3);
        @(negedge clk); card_present = 1; idle(3);
        // R9: level bits and a bus clear against them
        cur_req = "R9";
        wr(1, 16'h0C00); bus_sel = 0;
        @(negedge clk); rx_almost_full = 1; idle(2);
        wr(0, 16'h0C00); idle(1);
        @(negedge clk); tx_almost_empty = 1; rx_almost_full = 0; idle(2);
        @(negedge clk); tx_almost_empty = 0; idle(2);
        // R10: set and clear on the same edge
        cur_req = "R10";
        @(negedge clk); xfer_done = 1; bus_wr = 1; bus_sel = 0; bus_wdata = 16'h0008;
        idle(2);
        // R11: mixed pseudo-random traffic, spares stay zero
        cur_req = "R11";
        wr(1, 16'h7FFF); bus_sel = 0;
        for (int k = 0; k < 300; k++) begin
            int h;
            h = (k * 37 + 11) % 97;
            @(negedge clk);
            cmd_end = h[0]; cmd_timeout = h[3]; cmd_index = (h[1] ? 6'd12 : 6'd3);
            xfer_done = h[2]; card_err = (h % 7 == 0); card_busy = (h % 11 == 0);
            card_present = h[4]; rx_almost_full = h[5]; tx_almost_empty = h[6];
            bus_wr = (h % 5 == 0); bus_wdata = 16'(h * 613); bus_sel = (h % 13 == 0);
        end
        idle(2);
        // R1: reset again clears everything
        cur_req = "R1";
        @(negedge clk); rst_n = 0; idle(2);
        @(negedge clk); rst_n = 1; bus_sel = 1; idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule